// File: doc/BRIEF.md
# In-Place Radix-2 FFT Butterfly Engine

This block runs a complete radix-2 decimation-in-frequency FFT, or its inverse, over a frame of N complex fixed-point samples. The samples sit in a scratchpad outside the block. The engine reaches that memory through one synchronous read port and one write port. It reads the two partner words of each butterfly and writes the two results back into the same two locations, so the frame never needs a second buffer. When the run ends the spectrum is in bit-reversed order, and a level output reports this to the consumer.

A run begins with a one-cycle `start` while the engine is idle. The `inverse` input is sampled in that same cycle. The engine steps through every stage and every butterfly with no gaps, then pulses `done`. All twiddle factors are computed at elaboration time into a constant table. The inverse transform uses conjugated twiddles and applies no 1/N scaling.

Top module: `fft_ip_engine`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `rd_en`, `wr_en` and `spec_bitrev` are all low.
- R2: `start` is accepted only while `busy` is low, and `busy` is high in the cycle after. While a run is in progress, `start` and `inverse` have no effect on the run's memory writes or its length.
- R3: `busy` stays high for exactly 5·(N/2)·log2(N) cycles. `done` is high for exactly one cycle, which is the first cycle in which `busy` is low again.
- R4: Stages run from k = 1 up to log2(N). Let h = N>>k. Within a stage, butterflies are taken for every index i whose bit h is clear, in ascending order of i, and the partner index is j = i + h. For each butterfly the engine reads i and then j; read data returns one cycle after `rd_en`. It then writes i and then j, and no other address is written. At the end the memory holds the in-place transform.
- R5: Each memory word holds the real part in bits [63:32] and the imaginary part in bits [31:0]. Both parts are two's complement values with 24 fraction bits.
- R6: The word written to index i is the sum x[i] + x[j], taken separately on each part and saturated.
- R7: The word written to index j is w·(x[i] − x[j]). The complex product is formed exactly. Each part then has 2^15 added, is shifted arithmetically right by 16 bits, and is saturated.
- R8: The twiddle exponent is m = (i mod h)·2^(k−1). In forward mode, w has real part round(cos(2πm/N)·2^16) and imaginary part −round(sin(2πm/N)·2^16), where round means floor(x + 0.5).
- R9: In inverse mode the imaginary part of w is +round(sin(2πm/N)·2^16), and the output is not scaled. The mode is the value of `inverse` in the cycle in which `start` is accepted.
- R10: Both the sum path and the product path clamp each part to the range −2^31 to 2^31−1.
- R11: `spec_bitrev` goes high together with `done` and stays high until the next accepted `start`. It is low in the cycle after that `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transform (taken only when idle) |
| inverse | input | 1 | 1 selects the inverse transform, sampled with start |
| busy | output | 1 | A transform is running |
| done | output | 1 | One-cycle pulse at the end of a run |
| spec_bitrev | output | 1 | Memory holds a finished, bit-reversed spectrum |
| rd_en | output | 1 | Read request to the scratchpad |
| rd_addr | output | N_LOG2 | Read address |
| rd_data | input | 64 | Read data, valid one cycle after rd_en |
| wr_en | output | 1 | Write request to the scratchpad |
| wr_addr | output | N_LOG2 | Write address |
| wr_data | output | 64 | Write data {real, imag} |

## Verification
The properties assume that the scratchpad behaves as a one-cycle synchronous memory. A write must be visible to any read issued on a later cycle, and nothing else may modify the frame while `busy` is high. Otherwise the in-place pairing of write addresses with earlier read addresses and the order of stages would not mean anything. The stimulus keeps within these limits. The bench's memory model registers read data exactly one cycle after the request, and the frame is loaded only between runs, while `busy` is low. The only inputs driven during a run are the deliberate `start` and `inverse` toggles.

// File: rtl/fft_ip_pkg.sv
// Shared definitions for the in-place FFT engine.
// Holds the sequencer state encoding and the fixed cost of one butterfly.
package fft_ip_pkg;

    // Sequencer phases of one butterfly, plus the idle state.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_I,
        ST_RD_J,
        ST_CAP,
        ST_WR_I,
        ST_WR_J
    } bfly_st_e;

    // Clock cycles spent on every butterfly (two reads, capture, two writes).
    localparam int BFLY_CYCLES = 5;

endpackage

// File: rtl/fft_ip_addr_gen.sv
// Butterfly address generator.
// Tracks the stage k (1..N_LOG2) and the butterfly count inside that stage.
// From these it derives the pair (i, j = i + N>>k) and the twiddle exponent.
// Assumes N_LOG2 >= 2. It advances once per 'step' and restarts on 'clear'.
module fft_ip_addr_gen #(
    parameter int N_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [N_LOG2-1:0] idx_i,
    output logic [N_LOG2-1:0] idx_j,
    output logic [N_LOG2-2:0] tw_idx,
    output logic              last
);

    localparam int AW   = N_LOG2;
    localparam int BW   = N_LOG2 - 1;
    localparam int HALF = 1 << (N_LOG2 - 1);
    localparam int SW   = $clog2(N_LOG2 + 1);

    logic [SW-1:0] stg;
    logic [BW-1:0] bfly;
    logic [AW-1:0] bw;
    logic [AW-1:0] lo;
    logic [AW-1:0] lo_mask;
    int            sh;

    // Stage and butterfly counters; the stage stops at the final value.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            stg  <= SW'(1);
            bfly <= '0;
        end else if (step) begin
            if (bfly == BW'(HALF - 1)) begin
                bfly <= '0;
                if (stg != SW'(N_LOG2)) stg <= stg + 1'b1;
            end else begin
                bfly <= bfly + 1'b1;
            end
        end
    end

    // Split the count into group and offset, then form i, j and the exponent.
    always_comb begin
        sh      = N_LOG2 - int'(stg);
        lo_mask = AW'((1 << sh) - 1);
        bw      = AW'(bfly);
        lo      = bw & lo_mask;
        idx_i   = ((bw >> sh) << (sh + 1)) | lo;
        idx_j   = idx_i | AW'(1 << sh);
        tw_idx  = BW'(lo << (stg - 1'b1));
        last    = (bfly == BW'(HALF - 1)) && (stg == SW'(N_LOG2));
    end

endmodule

// File: rtl/fft_ip_twiddle_rom.sv
// Constant twiddle table.
// Entry m holds round(cos(2*pi*m/N)*2^TW_FRAC) and round(sin(2*pi*m/N)*2^TW_FRAC).
// Values are computed at elaboration; the sign convention is applied by the caller.
module fft_ip_twiddle_rom #(
    parameter int N_LOG2  = 4,
    parameter int TW_W    = 18,
    parameter int TW_FRAC = 16
) (
    input  logic        [N_LOG2-2:0] idx,
    output logic signed [TW_W-1:0]   cos_o,
    output logic signed [TW_W-1:0]   sin_o
);

    localparam int  HALF  = 1 << (N_LOG2 - 1);
    localparam real SCALE = 2.0 ** TW_FRAC;
    localparam real PI    = 3.14159265358979323846;

    logic signed [TW_W-1:0] cos_t [HALF];
    logic signed [TW_W-1:0] sin_t [HALF];

    // One constant entry per exponent value.
    for (genvar m = 0; m < HALF; m++) begin : g_ent
        localparam real TH = 2.0 * PI * real'(m) / real'(2 * HALF);
        localparam int  CV = $rtoi($floor($cos(TH) * SCALE + 0.5));
        localparam int  SV = $rtoi($floor($sin(TH) * SCALE + 0.5));
        assign cos_t[m] = TW_W'(CV);
        assign sin_t[m] = TW_W'(SV);
    end

    assign cos_o = cos_t[idx];
    assign sin_o = sin_t[idx];

endmodule

// File: rtl/fft_ip_bfly_dp.sv
// Butterfly arithmetic, purely combinational.
// Sum path: a + b per part, saturated to DW bits.
// Product path: (a - b) * w, exact, then round half up at bit TW_FRAC-1,
// arithmetic shift by TW_FRAC and saturation to DW bits.
module fft_ip_bfly_dp #(
    parameter int DW      = 32,
    parameter int TW_W    = 18,
    parameter int TW_FRAC = 16
) (
    input  logic signed [DW-1:0]   a_re,
    input  logic signed [DW-1:0]   a_im,
    input  logic signed [DW-1:0]   b_re,
    input  logic signed [DW-1:0]   b_im,
    input  logic signed [TW_W-1:0] w_re,
    input  logic signed [TW_W-1:0] w_im,
    output logic signed [DW-1:0]   s_re,
    output logic signed [DW-1:0]   s_im,
    output logic signed [DW-1:0]   p_re,
    output logic signed [DW-1:0]   p_im
);

    localparam int AW = DW + TW_W + 3;
    localparam logic signed [AW-1:0] RND = AW'(64'd1 << (TW_FRAC - 1));

    // Clamp a wide value into DW bits.
    function automatic logic signed [DW-1:0] clip(input logic signed [AW-1:0] v);
        if ((&v[AW-1:DW-1]) || !(|v[AW-1:DW-1])) clip = v[DW-1:0];
        else if (v[AW-1])                           clip = {1'b1, {(DW-1){1'b0}}};
        else                                        clip = {1'b0, {(DW-1){1'b1}}};
    endfunction

    logic signed [AW-1:0] ar, ai, br, bi, dr, di, wr, wi, acc_r, acc_i;

    // Widen, form the difference and the exact product, then round and clamp.
    always_comb begin
        ar    = AW'(a_re);
        ai    = AW'(a_im);
        br    = AW'(b_re);
        bi    = AW'(b_im);
        wr    = AW'(w_re);
        wi    = AW'(w_im);
        dr    = ar - br;
        di    = ai - bi;
        acc_r = dr * wr - di * wi;
        acc_i = dr * wi + di * wr;
        s_re  = clip(ar + br);
        s_im  = clip(ai + bi);
        p_re  = clip((acc_r + RND) >>> TW_FRAC);
        p_im  = clip((acc_i + RND) >>> TW_FRAC);
    end

endmodule

// File: rtl/fft_ip_engine.sv
// In-place radix-2 DIF FFT/IFFT engine (top).
// Each butterfly runs as a five-cycle sequence: read i, read j, capture, write i, write j.
// The scratchpad must return read data one cycle after rd_en, and no other agent
// may write it while busy. Because the sequence is strictly serial, every write
// of one stage lands before any read of the next.
module fft_ip_engine
    import fft_ip_pkg::*;
#(
    parameter int N_LOG2  = 4,
    parameter int DW      = 32,
    parameter int TW_W    = 18,
    parameter int TW_FRAC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              inverse,
    output logic              busy,
    output logic              done,
    output logic              spec_bitrev,
    output logic              rd_en,
    output logic [N_LOG2-1:0] rd_addr,
    input  logic [2*DW-1:0]   rd_data,
    output logic              wr_en,
    output logic [N_LOG2-1:0] wr_addr,
    output logic [2*DW-1:0]   wr_data
);

    bfly_st_e               st;
    logic                   inv_q, done_q, brev_q, accept, last;
    logic [2*DW-1:0]        a_q, b_q;
    logic [N_LOG2-1:0]      idx_i, idx_j;
    logic [N_LOG2-2:0]      tw_idx;
    logic signed [TW_W-1:0] tw_cos, tw_sin, w_im;
    logic signed [DW-1:0]   s_re, s_im, p_re, p_im;

    assign accept = (st == ST_IDLE) && start;

    fft_ip_addr_gen #(.N_LOG2(N_LOG2)) u_agen (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .step   (st == ST_WR_J),
        .idx_i  (idx_i),
        .idx_j  (idx_j),
        .tw_idx (tw_idx),
        .last   (last)
    );

    fft_ip_twiddle_rom #(.N_LOG2(N_LOG2), .TW_W(TW_W), .TW_FRAC(TW_FRAC)) u_rom (
        .idx   (tw_idx),
        .cos_o (tw_cos),
        .sin_o (tw_sin)
    );

    // Conjugate the twiddle for the inverse transform.
    assign w_im = inv_q ? tw_sin : -tw_sin;

    fft_ip_bfly_dp #(.DW(DW), .TW_W(TW_W), .TW_FRAC(TW_FRAC)) u_dp (
        .a_re (a_q[2*DW-1:DW]),
        .a_im (a_q[DW-1:0]),
        .b_re (b_q[2*DW-1:DW]),
        .b_im (b_q[DW-1:0]),
        .w_re (tw_cos),
        .w_im (w_im),
        .s_re (s_re),
        .s_im (s_im),
        .p_re (p_re),
        .p_im (p_im)
    );

    // Butterfly sequencer with operand capture, the done pulse and the order flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            inv_q  <= 1'b0;
            a_q    <= '0;
            b_q    <= '0;
            done_q <= 1'b0;
            brev_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                ST_IDLE: if (start) begin
                    st     <= ST_RD_I;
                    inv_q  <= inverse;
                    brev_q <= 1'b0;
                end
                ST_RD_I: st <= ST_RD_J;
                ST_RD_J: begin
                    a_q <= rd_data;
                    st  <= ST_CAP;
                end
                ST_CAP: begin
                    b_q <= rd_data;
                    st  <= ST_WR_I;
                end
                ST_WR_I: st <= ST_WR_J;
                ST_WR_J: if (last) begin
                    st     <= ST_IDLE;
                    done_q <= 1'b1;
                    brev_q <= 1'b1;
                end else begin
                    st <= ST_RD_I;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Memory port drive, decoded from the sequencer state.
    always_comb begin
        busy        = (st != ST_IDLE);
        done        = done_q;
        spec_bitrev = brev_q;
        rd_en       = (st == ST_RD_I) || (st == ST_RD_J);
        rd_addr     = (st == ST_RD_J) ? idx_j : idx_i;
        wr_en       = (st == ST_WR_I) || (st == ST_WR_J);
        wr_addr     = (st == ST_WR_J) ? idx_j : idx_i;
        wr_data     = (st == ST_WR_J) ? {p_re, p_im} : {s_re, s_im};
    end

endmodule

// File: rtl/fft_ip_engine_chk.sv
// Protocol checker for fft_ip_engine, attached by bind.
// It sees the ports only, and counts busy cycles to check the run length.
module fft_ip_engine_chk
    import fft_ip_pkg::*;
#(
    parameter int N_LOG2 = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              spec_bitrev,
    input logic              rd_en,
    input logic [N_LOG2-1:0] rd_addr,
    input logic              wr_en,
    input logic [N_LOG2-1:0] wr_addr
);

    localparam int RUN_LEN = BFLY_CYCLES * (1 << (N_LOG2 - 1)) * N_LOG2;

    int busy_cnt;

    // Length of the current busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= 0;
        else if (busy) busy_cnt <= busy_cnt + 1;
        else           busy_cnt <= 0;
    end

    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_ends_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && busy_cnt == RUN_LEN));
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_en && !wr_en));
    p_single_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));
    p_partner_above_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr > $past(wr_addr)));
    p_inplace_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !$past(wr_en)) |-> (wr_addr == $past(rd_addr, 3)));
    p_flag_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> spec_bitrev);
    p_flag_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !spec_bitrev);

endmodule

bind fft_ip_engine fft_ip_engine_chk #(.N_LOG2(N_LOG2)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .spec_bitrev (spec_bitrev),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr)
);

// File: tb/fft_ip_engine_tb_top.sv
// Scoreboard bench: a driver task models each run and queues the expected writes;
// a monitor pops and compares them as the engine writes to the bench memory.
module fft_ip_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_LOG2     = 4;
    localparam int N          = 1 << N_LOG2;
    localparam int HALF       = N / 2;
    localparam int DW         = 32;
    localparam int TW_FRAC    = 16;
    localparam int RUN_CYCLES = 5 * HALF * N_LOG2;
    localparam int WDOG_LIMIT = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              inverse = 1'b0;
    logic              busy, done, spec_bitrev, rd_en, wr_en;
    logic [N_LOG2-1:0] rd_addr, wr_addr;
    logic [2*DW-1:0]   rd_data, wr_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [63:0] mem   [N];
    logic [63:0] ref_m [N];
    longint      tw_c  [HALF];
    longint      tw_s  [HALF];

    logic [N_LOG2-1:0] q_addr [$];
    logic [63:0]       q_data [$];
    string             q_tag  [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    fft_ip_engine #(.N_LOG2(N_LOG2)) dut_i (
        .clk (clk), .rst_n (rst_n), .start (start), .inverse (inverse),
        .busy (busy), .done (done), .spec_bitrev (spec_bitrev),
        .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data)
    );

    // One-cycle synchronous scratchpad model.
    always @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        if (rd_en) rd_data <= mem[rd_addr];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG_LIMIT) begin
            checks++;
            fails++;
            $display("FAIL R3 watchdog expired actual=%0d expected<=%0d", cyc, WDOG_LIMIT);
            summary();
            $finish;
        end
    end

    // Monitor: compare every write with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            checks++;
            if (q_addr.size() == 0) begin
                fails++;
                $display("FAIL R4 unexpected write actual addr=%0d expected no write", wr_addr);
            end else begin
                logic [N_LOG2-1:0] ea;
                logic [63:0]       ed;
                string             et;
                ea = q_addr.pop_front();
                ed = q_data.pop_front();
                et = q_tag.pop_front();
                if (wr_addr !== ea || wr_data !== ed) begin
                    fails++;
                    $display("FAIL %s write actual addr=%0d data=%h expected addr=%0d data=%h",
                             et, wr_addr, wr_data, ea, ed);
                end
            end
        end
    end

    function automatic longint sat32(input longint v);
        if (v > 64'sd2147483647)  return 64'sd2147483647;
        if (v < -64'sd2147483648) return -64'sd2147483648;
        return v;
    endfunction

    // Model of the whole run from the requirements; queues writes in order.
    task automatic build_expect(input bit inv, input string ti, input string tj);
        for (int k = 1; k <= N_LOG2; k++) begin
            int h;
            h = N >> k;
            for (int i = 0; i < N; i++) begin
                if ((i & h) == 0) begin
                    int     j, m;
                    longint ar, ai, br, bi, dr, di, wr, wi, sr, si, pr, pi;
                    j  = i + h;
                    m  = (i % h) << (k - 1);
                    ar = longint'($signed(ref_m[i][63:32]));
                    ai = longint'($signed(ref_m[i][31:0]));
                    br = longint'($signed(ref_m[j][63:32]));
                    bi = longint'($signed(ref_m[j][31:0]));
                    sr = sat32(ar + br);
                    si = sat32(ai + bi);
                    dr = ar - br;
                    di = ai - bi;
                    wr = tw_c[m];
                    wi = inv ? tw_s[m] : -tw_s[m];
                    pr = sat32((dr * wr - di * wi + (64'sd1 <<< (TW_FRAC - 1))) >>> TW_FRAC);
                    pi = sat32((dr * wi + di * wr + (64'sd1 <<< (TW_FRAC - 1))) >>> TW_FRAC);
                    ref_m[i] = {sr[31:0], si[31:0]};
                    ref_m[j] = {pr[31:0], pi[31:0]};
                    q_addr.push_back(N_LOG2'(i));
                    q_data.push_back(ref_m[i]);
                    q_tag.push_back(ti);
                    q_addr.push_back(N_LOG2'(j));
                    q_data.push_back(ref_m[j]);
                    q_tag.push_back(tj);
                end
            end
        end
    endtask

    // Load a frame while idle: 0 small random, 1 ramp, 2 large values that clip.
    task automatic fill(input int mode);
        for (int n = 0; n < N; n++) begin
            logic signed [25:0] r1, r2;
            logic [31:0]        re, im;
            r1 = 26'($urandom);
            r2 = 26'($urandom);
            case (mode)
                0: begin re = 32'(r1); im = 32'(r2); end
                1: begin re = 32'(n << 20); im = -32'(n << 19); end
                default: begin
                    re = (n < N / 2) ? 32'h7800_0000 : 32'h8800_0000;
                    im = n[0] ? 32'h7800_0000 : 32'h8800_0000;
                end
            endcase
            mem[n] = {re, im};
        end
    endtask

    // Driver: model the run, start it, track busy/done/flag, check the final frame.
    task automatic run_case(input bit inv, input bit glitch, input string ti,
                            input string tj, input bit chk_clear);
        int bc;
        int mism;
        bc   = 0;
        mism = 0;
        for (int n = 0; n < N; n++) ref_m[n] = mem[n];
        build_expect(inv, ti, tj);
        @(negedge clk);
        start   = 1'b1;
        inverse = inv;
        @(negedge clk);
        start = 1'b0;
        if (chk_clear)
            check(spec_bitrev == 1'b0, "R11", "flag after start", spec_bitrev, 0);
        check(busy == 1'b1, "R2", "busy after start", busy, 1);
        while (busy && bc < 2 * RUN_CYCLES) begin
            bc++;
            if (glitch && bc == 20) begin
                start   = 1'b1;
                inverse = !inv;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start   = 1'b0;
        inverse = 1'b0;
        check(bc == RUN_CYCLES, "R3", "busy length", bc, RUN_CYCLES);
        check(done == 1'b1, "R3", "done on first idle cycle", done, 1);
        check(spec_bitrev == 1'b1, "R11", "flag with done", spec_bitrev, 1);
        @(negedge clk);
        check(done == 1'b0, "R3", "done width", done, 0);
        check(spec_bitrev == 1'b1, "R11", "flag held", spec_bitrev, 1);
        check(busy == 1'b0, "R2", "no restart from ignored start", busy, 0);
        check(q_addr.size() == 0, "R4", "writes outstanding", q_addr.size(), 0);
        for (int n = 0; n < N; n++) if (mem[n] !== ref_m[n]) mism++;
        check(mism == 0, "R4", "in-place final frame mismatches", mism, 0);
    endtask

    initial begin
        for (int m = 0; m < HALF; m++) begin
            real th;
            th = 2.0 * 3.14159265358979323846 * real'(m) / real'(N);
            tw_c[m] = longint'($rtoi($floor($cos(th) * 65536.0 + 0.5)));
            tw_s[m] = longint'($rtoi($floor($sin(th) * 65536.0 + 0.5)));
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0,        "R1", "busy after reset",  busy, 0);
        check(done == 1'b0,        "R1", "done after reset",  done, 0);
        check(rd_en == 1'b0,       "R1", "rd_en after reset", rd_en, 0);
        check(wr_en == 1'b0,       "R1", "wr_en after reset", wr_en, 0);
        check(spec_bitrev == 1'b0, "R1", "flag after reset",  spec_bitrev, 0);

        fill(0); run_case(1'b0, 1'b0, "R5 R6 fwd-sum", "R7 R8 fwd-prod", 1'b0);
        fill(1); run_case(1'b0, 1'b0, "R6 ramp-sum",   "R8 ramp-prod",   1'b1);
        fill(0); run_case(1'b1, 1'b0, "R9 inv-sum",    "R9 inv-prod",    1'b1);
        fill(2); run_case(1'b0, 1'b0, "R10 sat-sum",   "R10 sat-prod",   1'b1);
        fill(0); run_case(1'b1, 1'b1, "R2 R9 glitch",  "R2 R9 glitch",   1'b1);

        summary();
        $finish;
    end

endmodule